// File: doc/BRIEF.md
# Seconds real-time clock with alarms

This peripheral keeps wall-clock time as a 32-bit count of seconds plus a millisecond count, advanced by a slow tick strobe (nominally 32.768 kHz) that arrives synchronously in the bus clock domain. The millisecond count advances through a fractional accumulator, so a tick rate that does not divide evenly into milliseconds still gives an exact long-run rate. Live counters run on every tick. Once every few ticks the block copies the live values into bus-visible copies, and a busy flag marks the slow cycle that ends in that copy. Software may read at any time. It should write only while busy is low, and the block drops any write made while busy is high.

Reading the milliseconds register also stores the bus-visible seconds in a shadow register, so a later read of the shadow gives seconds that match the milliseconds just read. Two seconds alarms and one milliseconds alarm compare against the live counters as they change. A match sets a status bit, whether or not that bit is masked. Any status bit that is set while its mask bit is also set drives a level-high interrupt. The countdown interrupt sources have status and mask positions, but nothing sets them.

The bus is a single-cycle request port. A write takes effect on the clock edge that samples it. Read data appears on the output one cycle after the request and stays there until the next read.

Top module: `rtc_secs`

## Requirements
- R1: After reset every register reads 0, and busy_o and irq_o are low.
- R2: Each tick adds MS_PER_S to a fractional accumulator. When the sum reaches TICK_HZ, it wraps by TICK_HZ and milliseconds (offset 0x10, bits 9:0) steps by one. Milliseconds runs from 0 to MS_PER_S-1 and wraps to 0 as seconds steps by one. Seconds is 32 bits and wraps from 0xFFFFFFFF to 0.
- R3: busy_o, also bit 0 of offset 0x04, is high during one slow cycle in every COPY_PERIOD. That is the cycle after the first COPY_PERIOD-1 ticks counted from reset, and busy falls on the tick that follows.
- R4: The seconds register (0x08) and the milliseconds register change only on the tick that ends a busy window or on a seconds write. On that tick they take the live values that the tick produces.
- R5: A read of milliseconds copies the bus-visible seconds into the shadow register (0x0C) on the same edge. The shadow changes at no other time.
- R6: A seconds write loads the live and visible seconds and clears milliseconds and the accumulator. The block ignores any register write while busy_o is high.
- R7: Seconds alarm 0 (0x14) sets status bit 0, and seconds alarm 1 (0x18) sets status bit 1, on the tick where live seconds steps to the alarm value. An alarm value of 0 never sets its bit.
- R8: The milliseconds alarm (0x1C, bits 9:0) sets status bit 2 on the tick where live milliseconds steps to that value.
- R9: Writing status (0x2C) clears the bits written as 1. A bit that is set in the same cycle stays set. Status bits 3 and 4, the countdown sources, stay 0.
- R10: Mask (0x28) holds bits 4:0. Status bits set whatever the mask. irq_o is high exactly while some status bit and its mask bit are both 1.
- R11: Read data appears one cycle after the request. Offsets not listed here read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick strobe, one bus cycle wide |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after a read |
| busy_o | output | 1 | Copy window flag; writes are ignored while high |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bench builds the block with TICK_HZ = 2048 and keeps MS_PER_S = 1000 and COPY_PERIOD = 8. With these values a second passes in 2048 ticks, so a full second, the millisecond wrap, several seconds-alarm hits and the 32-bit seconds wrap at 0xFFFFFFFF all fall within a short run. The accumulator still carries irregularly, because 1000 does not divide 2048. The random phase sets alarms near the current time and places writes both inside and outside busy windows, so drops, alarm hits and clears that land in the same cycle all occur.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFF_BUSY   = 'h04;
  localparam int unsigned OFF_SEC    = 'h08;
  localparam int unsigned OFF_SHADOW = 'h0C;
  localparam int unsigned OFF_MS     = 'h10;
  localparam int unsigned OFF_SALM0  = 'h14;
  localparam int unsigned OFF_SALM1  = 'h18;
  localparam int unsigned OFF_MALM   = 'h1C;
  localparam int unsigned OFF_MASK   = 'h28;
  localparam int unsigned OFF_STAT   = 'h2C;

  localparam int unsigned SEC_ALM_N = 2;
  localparam int unsigned IRQ_N     = 5;

  typedef enum int unsigned {
    IRQ_SALM0  = 0,
    IRQ_SALM1  = 1,
    IRQ_MALM   = 2,
    IRQ_SCDN   = 3,
    IRQ_MSCDN  = 4
  } irq_bit_e;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int unsigned TICK_HZ     = 32768,
  parameter int unsigned MS_PER_S    = 1000,
  parameter int unsigned COPY_PERIOD = 8,
  localparam int unsigned FRAC_W     = $clog2(TICK_HZ),
  localparam int unsigned MS_W       = $clog2(MS_PER_S),
  localparam int unsigned DIV_W      = $clog2(COPY_PERIOD)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            load_i,
  input  logic [31:0]     load_val_i,
  output logic            sec_step_o,
  output logic            ms_step_o,
  output logic [31:0]     sec_nxt_o,
  output logic [MS_W-1:0] ms_nxt_o,
  output logic [31:0]     vis_sec_o,
  output logic [MS_W-1:0] vis_ms_o,
  output logic            busy_o
);
  logic [FRAC_W-1:0] frac_q, frac_nxt;
  logic [FRAC_W:0]   frac_sum;
  logic [MS_W-1:0]   ms_q;
  logic [31:0]       sec_q;
  logic [DIV_W-1:0]  div_q;
  logic              ms_carry, ms_wrap, copy;

  always_comb begin
    frac_sum  = {1'b0, frac_q} + (FRAC_W+1)'(MS_PER_S);
    ms_carry  = frac_sum >= (FRAC_W+1)'(TICK_HZ);
    frac_nxt  = ms_carry ? FRAC_W'(frac_sum - (FRAC_W+1)'(TICK_HZ)) : FRAC_W'(frac_sum);
    ms_wrap   = ms_carry && (ms_q == MS_W'(MS_PER_S - 1));
    ms_nxt_o  = ms_wrap ? '0 : (ms_carry ? ms_q + 1'b1 : ms_q);
    sec_nxt_o = ms_wrap ? sec_q + 32'd1 : sec_q;
  end

  assign busy_o     = (div_q == DIV_W'(COPY_PERIOD - 1));
  assign copy       = tick_i && busy_o;
  assign ms_step_o  = tick_i && !load_i && ms_carry;
  assign sec_step_o = tick_i && !load_i && ms_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q    <= '0;
      ms_q      <= '0;
      sec_q     <= '0;
      div_q     <= '0;
      vis_sec_o <= '0;
      vis_ms_o  <= '0;
    end else begin
      if (tick_i) div_q <= busy_o ? '0 : div_q + 1'b1;
      if (load_i) begin
        sec_q     <= load_val_i;
        ms_q      <= '0;
        frac_q    <= '0;
        vis_sec_o <= load_val_i;
        vis_ms_o  <= '0;
      end else if (tick_i) begin
        sec_q  <= sec_nxt_o;
        ms_q   <= ms_nxt_o;
        frac_q <= frac_nxt;
        if (copy) begin
          vis_sec_o <= sec_nxt_o;
          vis_ms_o  <= ms_nxt_o;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int unsigned SEC_N = 2,
  parameter int unsigned MS_W  = 10
) (
  input  logic                  sec_step_i,
  input  logic [31:0]           sec_nxt_i,
  input  logic                  ms_step_i,
  input  logic [MS_W-1:0]       ms_nxt_i,
  input  logic [SEC_N-1:0][31:0] sec_alm_i,
  input  logic [MS_W-1:0]       ms_alm_i,
  output logic [SEC_N-1:0]      sec_hit_o,
  output logic                  ms_hit_o
);
  for (genvar k = 0; k < SEC_N; k++) begin : g_sec
    // zero means disarmed
    assign sec_hit_o[k] = sec_step_i && (sec_alm_i[k] != '0) && (sec_nxt_i == sec_alm_i[k]);
  end
  assign ms_hit_o = ms_step_i && (ms_nxt_i == ms_alm_i);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] clr;
  assign clr = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      mask_o   <= '0;
    end else begin
      status_o <= (status_o & ~clr) | set_i;  // set wins
      if (mask_we_i) mask_o <= wdata_i;
    end
  end

  assign irq_o = |(status_o & mask_o);
endmodule

// File: rtl/rtc_secs.sv
module rtc_secs
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned TICK_HZ     = 32768,
  parameter int unsigned MS_PER_S    = 1000,
  parameter int unsigned COPY_PERIOD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              busy_o,
  output logic              irq_o
);
  localparam int unsigned MS_W = $clog2(MS_PER_S);

  logic                     wr_ok, rd;
  logic                     sel_busy, sel_sec, sel_shadow, sel_ms, sel_malm, sel_mask, sel_stat;
  logic [SEC_ALM_N-1:0]     sel_salm;
  logic                     sec_step, ms_step;
  logic [31:0]              sec_nxt, vis_sec, shadow_q;
  logic [MS_W-1:0]          ms_nxt, vis_ms, malm_q;
  logic [SEC_ALM_N-1:0][31:0] salm_q;
  logic [SEC_ALM_N-1:0]     sec_hit;
  logic                     ms_hit;
  logic [IRQ_N-1:0]         irq_set, status_w, mask_w;
  logic [31:0]              rd_mux;

  assign sel_busy   = addr_i == ADDR_W'(OFF_BUSY);
  assign sel_sec    = addr_i == ADDR_W'(OFF_SEC);
  assign sel_shadow = addr_i == ADDR_W'(OFF_SHADOW);
  assign sel_ms     = addr_i == ADDR_W'(OFF_MS);
  assign sel_salm[0] = addr_i == ADDR_W'(OFF_SALM0);
  assign sel_salm[1] = addr_i == ADDR_W'(OFF_SALM1);
  assign sel_malm   = addr_i == ADDR_W'(OFF_MALM);
  assign sel_mask   = addr_i == ADDR_W'(OFF_MASK);
  assign sel_stat   = addr_i == ADDR_W'(OFF_STAT);

  assign wr_ok = req_i && we_i && !busy_o;
  assign rd    = req_i && !we_i;

  rtc_timebase #(
    .TICK_HZ    (TICK_HZ),
    .MS_PER_S   (MS_PER_S),
    .COPY_PERIOD(COPY_PERIOD)
  ) u_timebase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .load_i    (wr_ok && sel_sec),
    .load_val_i(wdata_i),
    .sec_step_o(sec_step),
    .ms_step_o (ms_step),
    .sec_nxt_o (sec_nxt),
    .ms_nxt_o  (ms_nxt),
    .vis_sec_o (vis_sec),
    .vis_ms_o  (vis_ms),
    .busy_o    (busy_o)
  );

  rtc_alarm_unit #(
    .SEC_N(SEC_ALM_N),
    .MS_W (MS_W)
  ) u_alarm (
    .sec_step_i(sec_step),
    .sec_nxt_i (sec_nxt),
    .ms_step_i (ms_step),
    .ms_nxt_i  (ms_nxt),
    .sec_alm_i (salm_q),
    .ms_alm_i  (malm_q),
    .sec_hit_o (sec_hit),
    .ms_hit_o  (ms_hit)
  );

  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_SALM0] = sec_hit[0];
    irq_set[IRQ_SALM1] = sec_hit[1];
    irq_set[IRQ_MALM]  = ms_hit;
  end

  rtc_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (irq_set),
    .clr_we_i (wr_ok && sel_stat),
    .mask_we_i(wr_ok && sel_mask),
    .wdata_i  (wdata_i[IRQ_N-1:0]),
    .status_o (status_w),
    .mask_o   (mask_w),
    .irq_o    (irq_o)
  );

  for (genvar k = 0; k < SEC_ALM_N; k++) begin : g_salm
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   salm_q[k] <= '0;
      else if (wr_ok && sel_salm[k]) salm_q[k] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      malm_q   <= '0;
      shadow_q <= '0;
      rdata_o  <= '0;
    end else begin
      if (wr_ok && sel_malm) malm_q <= wdata_i[MS_W-1:0];
      if (rd && sel_ms)      shadow_q <= vis_sec;  // coherent snapshot
      if (rd)                rdata_o <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_busy)    rd_mux = {31'd0, busy_o};
    if (sel_sec)     rd_mux = vis_sec;
    if (sel_shadow)  rd_mux = shadow_q;
    if (sel_ms)      rd_mux = 32'(vis_ms);
    if (sel_salm[0]) rd_mux = salm_q[0];
    if (sel_salm[1]) rd_mux = salm_q[1];
    if (sel_malm)    rd_mux = 32'(malm_q);
    if (sel_mask)    rd_mux = 32'(mask_w);
    if (sel_stat)    rd_mux = 32'(status_w);
  end
endmodule

// File: rtl/rtc_secs_chk.sv
module rtc_secs_chk
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned COPY_PERIOD = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              busy_o,
  input logic              irq_o,
  input logic [IRQ_N-1:0]  mask_i,
  input logic [IRQ_N-1:0]  status_i,
  input logic [IRQ_N-1:0]  set_i
);
  localparam int unsigned CNT_W = $clog2(COPY_PERIOD) + 1;
  logic [CNT_W-1:0] idle_ticks;
  logic             unmapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           idle_ticks <= '0;
    else if (busy_o)       idle_ticks <= '0;
    else if (tick_i)       idle_ticks <= idle_ticks + 1'b1;
  end

  assign unmapped = !(addr_i inside {ADDR_W'(OFF_BUSY), ADDR_W'(OFF_SEC), ADDR_W'(OFF_SHADOW),
                                     ADDR_W'(OFF_MS), ADDR_W'(OFF_SALM0), ADDR_W'(OFF_SALM1),
                                     ADDR_W'(OFF_MALM), ADDR_W'(OFF_MASK), ADDR_W'(OFF_STAT)});

  assert_busy_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> idle_ticks == CNT_W'(COPY_PERIOD - 1));

  assert_busy_write_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i && we_i && addr_i == ADDR_W'(OFF_MASK)) |=> $stable(mask_i));

  assert_w1c_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && we_i && addr_i == ADDR_W'(OFF_STAT) && wdata_i[IRQ_N-1:0] == '1 && set_i == '0)
    |=> status_i == '0);

  assert_cdn_inert_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[IRQ_MSCDN:IRQ_SCDN] == 2'b00);

  assert_mask_zero_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && we_i && addr_i == ADDR_W'(OFF_MASK) && wdata_i[IRQ_N-1:0] == '0) |=> !irq_o);

  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && unmapped) |=> rdata_o == 32'd0);
endmodule

bind rtc_secs rtc_secs_chk #(.ADDR_W(ADDR_W), .COPY_PERIOD(COPY_PERIOD)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .busy_o  (busy_o),
  .irq_o   (irq_o),
  .mask_i  (mask_w),
  .status_i(status_w),
  .set_i   (irq_set)
);

// File: tb/test_rtc_secs.sv
module test_rtc_secs;
  localparam int CLK_PERIOD = 10;
  localparam int HZ   = 2048;
  localparam int MSPS = 1000;
  localparam int CP   = 8;

  logic        clk = 0, rst_n = 0;
  logic        tick = 0, req = 0, we = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, irq;

  rtc_secs #(.ADDR_W(6), .TICK_HZ(HZ), .MS_PER_S(MSPS), .COPY_PERIOD(CP)) i_rtc_secs (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;

  // reference state
  int unsigned m_sec, m_ms, m_frac, m_div, m_vsec, m_vms, m_shadow, m_malm, m_rdata;
  int unsigned m_alm[2];
  bit [4:0]    m_mask, m_stat;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [5:0] a);
    case (a)
      6'h04: return "R3 busy reg";
      6'h08: return "R4 seconds";
      6'h0C: return "R5 shadow";
      6'h10: return "R2 millis";
      6'h14, 6'h18: return "R7 sec alarm";
      6'h1C: return "R8 ms alarm";
      6'h28: return "R10 mask";
      6'h2C: return "R9 status";
      default: return "R11 unmapped";
    endcase
  endfunction

  function automatic int unsigned rd_val(logic [5:0] a);
    case (a)
      6'h04: return (m_div == CP-1) ? 1 : 0;
      6'h08: return m_vsec;
      6'h0C: return m_shadow;
      6'h10: return m_vms;
      6'h14: return m_alm[0];
      6'h18: return m_alm[1];
      6'h1C: return m_malm;
      6'h28: return 32'(m_mask);
      6'h2C: return 32'(m_stat);
      default: return 0;
    endcase
  endfunction

  function automatic bit m_busy();
    return m_div == CP-1;
  endfunction

  task automatic model(bit tk, bit rq, bit w, logic [5:0] a, logic [31:0] d);
    bit wr_ok = rq && w && !m_busy();
    bit [4:0] set = '0;
    bit [4:0] clr = '0;
    if (rq && !w) begin
      m_rdata = rd_val(a);
      if (a == 6'h10) m_shadow = m_vsec;
    end
    if (wr_ok && a == 6'h08) begin
      m_sec = d; m_ms = 0; m_frac = 0; m_vsec = d; m_vms = 0;
      if (tk) m_div = (m_div + 1) % CP;
    end else if (tk) begin
      m_frac += MSPS;
      if (m_frac >= HZ) begin
        m_frac -= HZ;
        if (m_ms == MSPS-1) begin
          m_ms = 0; m_sec = m_sec + 1;
          if (m_alm[0] != 0 && m_sec == m_alm[0]) set[0] = 1;
          if (m_alm[1] != 0 && m_sec == m_alm[1]) set[1] = 1;
        end else m_ms++;
        if (m_ms == m_malm) set[2] = 1;
      end
      if (m_busy()) begin m_vsec = m_sec; m_vms = m_ms; end
      m_div = (m_div + 1) % CP;
    end
    if (wr_ok && a == 6'h2C) clr = d[4:0];
    m_stat = (m_stat & ~clr) | set;
    if (wr_ok && a == 6'h28) m_mask = d[4:0];
    if (wr_ok && a == 6'h14) m_alm[0] = d;
    if (wr_ok && a == 6'h18) m_alm[1] = d;
    if (wr_ok && a == 6'h1C) m_malm = d % 1024;
  endtask

  task automatic step(bit tk, bit rq, bit w, logic [5:0] a, logic [31:0] d);
    tick = tk; req = rq; we = w; addr = a; wdata = d;
    @(posedge clk);
    model(tk, rq, w, a, d);
    @(negedge clk);
    tick = 0; req = 0; we = 0;
    chk("R3 busy_o", 32'(busy), 32'(m_busy()));
    chk("R10 irq_o", 32'(irq), 32'(|(m_stat & m_mask)));
    if (rq && !w) chk(tag_of(a), rdata, m_rdata);
  endtask

  task automatic rd(logic [5:0] a);
    step(0, 1, 0, a, 0);
  endtask

  // waits for a non-busy slot, then writes
  task automatic wr(logic [5:0] a, logic [31:0] d);
    while (m_busy()) step(1, 0, 0, 0, 0);
    step(0, 1, 1, a, d);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 300000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] amap[10] = '{6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h28, 6'h2C, 6'h20};
    void'($urandom(32'd20240611));
    m_sec = 0; m_ms = 0; m_frac = 0; m_div = 0; m_vsec = 0; m_vms = 0;
    m_shadow = 0; m_malm = 0; m_rdata = 0; m_alm[0] = 0; m_alm[1] = 0;
    m_mask = 0; m_stat = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy_o", 32'(busy), 0);
    chk("R1 irq_o", 32'(irq), 0);
    foreach (amap[i]) begin
      step(0, 1, 0, amap[i], 0);
      chk("R1 reset read", rdata, 0);
    end

    // R2/R4 free running with stale copies between windows
    for (int i = 0; i < 60; i++) begin ticks(5); rd(6'h10); rd(6'h08); end

    // R5 shadow coherence
    rd(6'h10); rd(6'h0C);

    // R6 seconds load, R7 alarm 0 with mask off then on
    wr(6'h08, 32'd100);
    rd(6'h08); rd(6'h10);
    wr(6'h14, 32'd101);
    ticks(HZ + 16);
    rd(6'h2C);
    chk("R7 alarm0 status", rdata & 1, 1);
    chk("R10 masked irq low", 32'(irq), 0);
    wr(6'h28, 32'h1);
    chk("R10 irq high", 32'(irq), 1);
    wr(6'h2C, 32'hFFFF_FFFF);
    chk("R9 clear irq", 32'(irq), 0);

    // R6 write during busy dropped
    while (!m_busy()) step(1, 0, 0, 0, 0);
    step(0, 1, 1, 6'h28, 32'h1F);
    rd(6'h28);
    chk("R6 busy write dropped", rdata, 32'h1);

    // R7 zero alarm disarmed across 32-bit wrap
    wr(6'h14, 32'd0); wr(6'h18, 32'd0); wr(6'h28, 32'h1F);
    wr(6'h08, 32'hFFFF_FFFF);
    ticks(HZ + 16);
    rd(6'h08); rd(6'h2C);
    chk("R7 zero alarm quiet", rdata & 3, 0);

    // R8 ms alarm
    wr(6'h1C, 32'd5);
    ticks(40);
    rd(6'h2C);
    chk("R8 ms alarm hit", (rdata >> 2) & 1, 1);
    wr(6'h2C, 32'h4);

    // R7 alarm 1
    wr(6'h08, 32'd7); wr(6'h18, 32'd8);
    ticks(HZ + 16);
    rd(6'h2C);
    chk("R7 alarm1 status", (rdata >> 1) & 1, 1);

    // R11 unmapped
    rd(6'h24); rd(6'h00); rd(6'h3C);

    // random mix
    for (int i = 0; i < 30000; i++) begin
      int unsigned r = $urandom_range(0, 99);
      bit tk = $urandom_range(0, 1);
      if (r < 30) step(tk, 1, 0, amap[$urandom_range(0, 9)], 0);
      else if (r < 40) begin
        int unsigned k = $urandom_range(0, 6);
        case (k)
          0: step(tk, 1, 1, 6'h14, m_sec + $urandom_range(0, 2));
          1: step(tk, 1, 1, 6'h18, m_sec + $urandom_range(0, 2));
          2: step(tk, 1, 1, 6'h1C, $urandom_range(0, 999));
          3: step(tk, 1, 1, 6'h28, $urandom);
          4: step(tk, 1, 1, 6'h2C, $urandom);
          5: step(tk, 1, 1, 6'h08, ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom_range(0, 50));
          default: step(tk, 1, 1, 6'h2C, 32'hFFFF_FFFF);
        endcase
      end else step(tk, 0, 0, 0, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule